// File: doc/BRIEF.md
# Blended-Curve Histogram Equalizer

This block equalizes a 14-bit monochrome pixel stream, one frame at a time. While a frame arrives, it counts how many pixels fall into each intensity bin. The bin is the upper part of the pixel word. When the last pixel of the frame is in, the block walks the bins once during vertical blanking. On that walk it forms the running cumulative count, scales it to the output range, and blends it with a straight identity ramp. The blend is set by a weight alpha that was sampled when the frame started. Each result is written into a remap table. A weight of one gives full equalization. A weight of zero leaves the picture unchanged apart from bit reduction. Values in between hold back the noise boost that plain equalization gives to flat backgrounds.

The table built from one frame takes effect on the first pixel of the next frame that the block accepts. Remapping goes through a pair of alternating tables, so a frame is never mapped through a half-written curve. Normalization by the fixed frame size uses a reciprocal constant and a multiply, with no divider. Back-to-back pixels in the same bin are forwarded around the counter memory's read latency. A frame that starts before the table walk has finished is still mapped, but it is not counted, and a sticky overrun flag is raised.

Top module: `blend_heq`

## Requirements
- R1: `valid_o` and `sof_o` repeat `valid_i` and `sof_i`, and `pix_o` carries the remapped value of `pix_i`, all exactly one clock later. When `valid_i` is low, `valid_o` is low on the next cycle.
- R2: Until the first table has been built after reset, `pix_o` is the bin of the pixel, `pix_i[PIX_W-1 -: BIN_W]`.
- R3: Each table is built only from the pixels of the accepted frame just ended. The histogram of a frame counts the bin `pix_i[PIX_W-1 -: BIN_W]` of each of its FRAME_PIX valid pixels. The frame opens with `sof_i` on its first pixel.
- R4: For bin b with cumulative count c(b), the number of pixels in bins 0..b, the table entry is floor((a*e + (256-a)*b)/256). Here e = min(M, floor(c*M*K / 2^RSH)), M = 2^BIN_W-1 and K = floor(2^RSH / FRAME_PIX).
- R5: The weight a is `alpha_i`, an unsigned value with 8 fractional bits, sampled on the accepted start pixel only. Values above 256 are used as 256.
- R6: The table of an accepted frame maps every pixel of the next accepted frame, from its start pixel onward.
- R7: Consecutive pixels in the same bin are each counted once, with no count lost.
- R8: A start pixel that arrives while a table is still being built sets `overrun_o`, which stays high until reset. That frame is mapped with the table already in use, is not counted, and defers the table switch to the next accepted start.
- R9: Reset clears `valid_o`, `sof_o` and `overrun_o`. It also clears the notion of a built table. The histogram memory is cleared in the BINS cycles after reset, and no frame may start during that time.
- R10: A start pixel that follows the last pixel of an accepted frame after at least BINS+2 cycles with `valid_i` low is accepted without overrun. After BINS+1 such cycles it is an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | PIX_W | Input pixel value |
| valid_i | input | 1 | Input pixel present this cycle |
| sof_i | input | 1 | First pixel of a frame, qualified by valid_i |
| alpha_i | input | AF_W+1 | Blend weight, 8 fractional bits |
| pix_o | output | BIN_W | Remapped pixel |
| valid_o | output | 1 | Output pixel present |
| sof_o | output | 1 | First output pixel of a frame |
| overrun_o | output | 1 | Sticky: a frame began while the table was being built |

## Verification
Each remapped pixel appears on the cycle after it is driven. The bench therefore drives on the falling edge and compares one nanosecond after the following rising edge, against a table it computes from the previous accepted frame. A table is ready BINS+2 idle cycles after a frame's last pixel. The bench places start pixels at exactly that gap and at one cycle less, to pin down the acceptance boundary. The overrun flag updates on the edge that takes the offending start pixel. It is read after the frame ends and again after later frames, to confirm that it stays set.

// File: rtl/heq_pkg.sv
package heq_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_ACC,
    ST_DRAIN,
    ST_BUILD,
    ST_FIN
  } heq_state_e;
endpackage

// File: rtl/heq_hist.sv
module heq_hist #(
  parameter int BIN_W = 8,
  parameter int CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_v_i,
  input  logic [BIN_W-1:0] acc_bin_i,
  input  logic             clr_i,
  input  logic [BIN_W-1:0] clr_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int BINS = 1 << BIN_W;

  logic [CNT_W-1:0] mem [BINS];
  logic [CNT_W-1:0] rd_q, last_cnt, base, inc;
  logic [BIN_W-1:0] s1_bin, last_bin, rd_addr, wr_addr;
  logic             s1_v, last_v, wr_en;
  logic [CNT_W-1:0] wr_data;

  // forward the previous write when it hit the bin now being incremented
  assign base    = (last_v && last_bin == s1_bin) ? last_cnt : rd_q;
  assign inc     = base + CNT_W'(1);
  assign rd_addr = clr_i ? clr_addr_i : acc_bin_i;
  assign wr_en   = clr_i | s1_v;
  assign wr_addr = clr_i ? clr_addr_i : s1_bin;
  assign wr_data = clr_i ? '0 : inc;
  assign rd_data_o = rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v     <= 1'b0;
      s1_bin   <= '0;
      last_v   <= 1'b0;
      last_bin <= '0;
      last_cnt <= '0;
    end else begin
      s1_v     <= acc_v_i & ~clr_i;
      s1_bin   <= acc_bin_i;
      last_v   <= s1_v & ~clr_i;
      last_bin <= s1_bin;
      last_cnt <= inc;
    end
  end
endmodule

// File: rtl/heq_curve.sv
module heq_curve #(
  parameter int BIN_W     = 8,
  parameter int CNT_W     = 19,
  parameter int FRAME_PIX = 327680,
  parameter int AF_W      = 8,
  parameter int RSH       = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dv_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [AF_W:0]    alpha_i,
  output logic             we_o,
  output logic [BIN_W-1:0] waddr_o,
  output logic [BIN_W-1:0] wdata_o
);
  localparam int          MAXV  = (1 << BIN_W) - 1;
  localparam int          ONE   = 1 << AF_W;
  localparam logic [63:0] RECIP = (64'd1 << RSH) / 64'(FRAME_PIX);

  logic [CNT_W-1:0] cdf_q, cdf_n;
  logic [63:0]      prod, eq_full;
  logic [BIN_W-1:0] eq_v;
  logic [31:0]      mix;

  assign cdf_n   = cdf_q + cnt_i;
  assign prod    = 64'(cdf_n) * 64'(MAXV) * RECIP;
  assign eq_full = prod >> RSH;
  assign eq_v    = (eq_full > 64'(MAXV)) ? BIN_W'(MAXV) : eq_full[BIN_W-1:0];
  assign mix     = 32'(alpha_i) * 32'(eq_v) + (32'(ONE) - 32'(alpha_i)) * 32'(bin_i);

  assign we_o    = dv_i;
  assign waddr_o = bin_i;
  assign wdata_o = mix[AF_W +: BIN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cdf_q <= '0;
    else if (start_i) cdf_q <= '0;
    else if (dv_i)    cdf_q <= cdf_n;
  end
endmodule

// File: rtl/heq_map.sv
module heq_map #(
  parameter int BIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             swap_i,
  input  logic             we_i,
  input  logic [BIN_W-1:0] waddr_i,
  input  logic [BIN_W-1:0] wdata_i,
  input  logic             pix_v_i,
  input  logic             pix_sof_i,
  input  logic [BIN_W-1:0] bin_i,
  output logic             pix_v_o,
  output logic             pix_sof_o,
  output logic [BIN_W-1:0] pix_o
);
  localparam int BINS = 1 << BIN_W;

  logic             act, ok, use_bank, use_ok;
  logic [BIN_W-1:0] rd_w [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [BIN_W-1:0] tbl [BINS];
    always_ff @(posedge clk_i) begin
      if (we_i && act != 1'(g)) tbl[waddr_i] <= wdata_i;
    end
    assign rd_w[g] = tbl[bin_i];
  end

  assign use_bank = swap_i ? ~act : act;
  assign use_ok   = swap_i | ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act       <= 1'b0;
      ok        <= 1'b0;
      pix_v_o   <= 1'b0;
      pix_sof_o <= 1'b0;
      pix_o     <= '0;
    end else begin
      act       <= use_bank;
      ok        <= use_ok;
      pix_v_o   <= pix_v_i;
      pix_sof_o <= pix_v_i & pix_sof_i;
      if (pix_v_i) pix_o <= use_ok ? rd_w[use_bank] : bin_i;
    end
  end
endmodule

// File: rtl/blend_heq.sv
module blend_heq
  import heq_pkg::*;
#(
  parameter int PIX_W     = 14,
  parameter int BIN_W     = 8,
  parameter int FRAME_PIX = 327680,
  parameter int AF_W      = 8,
  parameter int RSH       = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic [AF_W:0]    alpha_i,
  output logic [BIN_W-1:0] pix_o,
  output logic             valid_o,
  output logic             sof_o,
  output logic             overrun_o
);
  localparam int BINS  = 1 << BIN_W;
  localparam int CNT_W = $clog2(FRAME_PIX + 1);
  localparam int ONE   = 1 << AF_W;

  heq_state_e       state;
  logic [CNT_W-1:0] pcnt, hcnt;
  logic [BIN_W-1:0] ba, b_bin, in_bin, c_addr, c_data;
  logic [AF_W:0]    alpha_q, alpha_c;
  logic             b_v, pend, ovr, c_we;
  logic             sof_ok, acc_v, sweep, busy, swap, last_pix;

  assign in_bin   = pix_i[PIX_W-1 -: BIN_W];
  assign sof_ok   = valid_i && sof_i && state == ST_IDLE;
  assign acc_v    = valid_i && (state == ST_ACC || sof_ok);
  assign sweep    = state == ST_INIT || state == ST_BUILD;
  assign busy     = state == ST_DRAIN || state == ST_BUILD || state == ST_FIN;
  assign swap     = sof_ok && pend;
  assign last_pix = valid_i && pcnt == CNT_W'(FRAME_PIX - 1);
  assign alpha_c  = (alpha_i > (AF_W+1)'(ONE)) ? (AF_W+1)'(ONE) : alpha_i;
  assign overrun_o = ovr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_INIT;
      pcnt    <= '0;
      ba      <= '0;
      b_v     <= 1'b0;
      b_bin   <= '0;
      alpha_q <= '0;
      pend    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      b_v   <= state == ST_BUILD;
      b_bin <= ba;
      if (valid_i && sof_i && busy) ovr <= 1'b1;
      unique case (state)
        ST_INIT: begin
          ba <= ba + BIN_W'(1);
          if (ba == BIN_W'(BINS - 1)) state <= ST_IDLE;
        end
        ST_IDLE: if (sof_ok) begin
          pcnt    <= CNT_W'(1);
          alpha_q <= alpha_c;
          pend    <= 1'b0;
          state   <= ST_ACC;
        end
        ST_ACC: if (valid_i) begin
          pcnt <= pcnt + CNT_W'(1);
          if (last_pix) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          ba    <= '0;
          state <= ST_BUILD;
        end
        ST_BUILD: begin
          ba <= ba + BIN_W'(1);
          if (ba == BIN_W'(BINS - 1)) state <= ST_FIN;
        end
        ST_FIN: begin
          pend  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  heq_hist #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_v_i    (acc_v),
    .acc_bin_i  (in_bin),
    .clr_i      (sweep),
    .clr_addr_i (ba),
    .rd_data_o  (hcnt)
  );

  heq_curve #(
    .BIN_W(BIN_W), .CNT_W(CNT_W), .FRAME_PIX(FRAME_PIX), .AF_W(AF_W), .RSH(RSH)
  ) u_curve (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (state == ST_DRAIN),
    .dv_i    (b_v),
    .bin_i   (b_bin),
    .cnt_i   (hcnt),
    .alpha_i (alpha_q),
    .we_o    (c_we),
    .waddr_o (c_addr),
    .wdata_o (c_data)
  );

  heq_map #(.BIN_W(BIN_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_i    (swap),
    .we_i      (c_we),
    .waddr_i   (c_addr),
    .wdata_i   (c_data),
    .pix_v_i   (valid_i),
    .pix_sof_i (sof_i),
    .bin_i     (in_bin),
    .pix_v_o   (valid_o),
    .pix_sof_o (sof_o),
    .pix_o     (pix_o)
  );
endmodule

// File: rtl/blend_heq_chk.sv
module blend_heq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic sof_i,
  input logic valid_o,
  input logic sof_o,
  input logic overrun_o,
  input logic busy_i
);
  a_r1_valid_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r1_sof_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> sof_o);
  a_r8_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i && busy_i) |=> overrun_o);
  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind blend_heq blend_heq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .sof_i     (sof_i),
  .valid_o   (valid_o),
  .sof_o     (sof_o),
  .overrun_o (overrun_o),
  .busy_i    (busy)
);

// File: tb/blend_heq_tb.sv
`timescale 1ns/1ps
module blend_heq_tb;
  localparam int PIX_W = 6, BIN_W = 4, FRAME_PIX = 16, AF_W = 8, RSH = 24;
  localparam int BINS = 1 << BIN_W;
  localparam int MAXV = BINS - 1;
  localparam int NVEC = 8;
  localparam int GAP  = 30;
  // {kind, seed, alpha}
  localparam logic [17:0] VEC [NVEC] = '{
    {3'd1, 6'd0,  9'd256}, {3'd0, 6'd21, 9'd128},
    {3'd2, 6'd5,  9'd0},   {3'd3, 6'd3,  9'd300},
    {3'd4, 6'd40, 9'd64},  {3'd1, 6'd7,  9'd200},
    {3'd0, 6'd63, 9'd256}, {3'd2, 6'd17, 9'd255}
  };

  logic             clk = 1'b0, rst_ni = 1'b0;
  logic [PIX_W-1:0] pix_i = '0;
  logic             valid_i = 1'b0, sof_i = 1'b0;
  logic [AF_W:0]    alpha_i = '0;
  logic [BIN_W-1:0] pix_o;
  logic             valid_o, sof_o, overrun_o;

  int n_chk = 0, n_fail = 0;
  int exp_tbl [BINS];
  int nxt_tbl [BINS];
  bit exp_ok;

  always #2 clk = ~clk;

  blend_heq #(.PIX_W(PIX_W), .BIN_W(BIN_W), .FRAME_PIX(FRAME_PIX), .AF_W(AF_W), .RSH(RSH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix_i), .valid_i(valid_i), .sof_i(sof_i),
    .alpha_i(alpha_i), .pix_o(pix_o), .valid_o(valid_o), .sof_o(sof_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pgen(input int kind, input int seed, input int i);
    case (kind)
      0: return seed;
      1: return (seed + i * 4) & 63;
      2: return i[0] ? seed : (seed ^ 42);
      3: return (seed + (i >> 1) * 8) & 63;
      default: return (i < 12) ? seed : 63 - i;
    endcase
  endfunction

  // reference curve from R3/R4/R5
  task automatic model(input int kind, input int seed, input int alpha);
    int h [BINS];
    longint c;
    int a;
    for (int b = 0; b < BINS; b++) h[b] = 0;
    for (int i = 0; i < FRAME_PIX; i++) h[pgen(kind, seed, i) >> (PIX_W - BIN_W)]++;
    a = (alpha > 256) ? 256 : alpha;
    c = 0;
    for (int b = 0; b < BINS; b++) begin
      longint e;
      c += h[b];
      e = (c * MAXV * ((64'd1 << RSH) / FRAME_PIX)) >> RSH;
      if (e > MAXV) e = MAXV;
      nxt_tbl[b] = int'((a * e + (256 - a) * b) >> 8);
    end
  endtask

  task automatic promote();
    for (int b = 0; b < BINS; b++) exp_tbl[b] = nxt_tbl[b];
    exp_ok = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
      sof_i   = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic send(input int kind, input int seed, input int alpha, input string req);
    for (int i = 0; i < FRAME_PIX; i++) begin
      int p, e;
      @(negedge clk);
      p = pgen(kind, seed, i);
      pix_i   = PIX_W'(p);
      valid_i = 1'b1;
      sof_i   = (i == 0);
      alpha_i = (i == 0) ? (AF_W+1)'(alpha) : ~(AF_W+1)'(alpha); // R5 sample only at start
      @(posedge clk);
      #1;
      e = exp_ok ? exp_tbl[p >> (PIX_W - BIN_W)] : (p >> (PIX_W - BIN_W));
      chk(valid_o && (sof_o == (i == 0)), "R1 valid/sof", {valid_o, sof_o}, {1'b1, i == 0});
      chk(int'(pix_o) == e, req, int'(pix_o), e);
      if (i == 7) begin
        @(negedge clk);
        valid_i = 1'b0;
        sof_i   = 1'b0;
        @(posedge clk);
        #1;
        chk(!valid_o, "R1 bubble", valid_o, 0);
      end
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!valid_o && !sof_o && !overrun_o, "R9 reset outputs", {valid_o, sof_o, overrun_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(BINS + 4);

    // table walk: frame 0 identity (R2), then each frame uses the previous curve (R3 R4 R6; R7 on kind 0/3)
    for (int f = 0; f < NVEC; f++) begin
      int kind, seed, alpha;
      kind  = int'(VEC[f][17:15]);
      seed  = int'(VEC[f][14:9]);
      alpha = int'(VEC[f][8:0]);
      send(kind, seed, alpha, (f == 0) ? "R2 identity" : "R4 R6 R7 curve");
      model(kind, seed, alpha);
      idle(GAP);
      promote();
    end

    // R10 boundary: BINS+2 idle cycles accepted
    send(1, 9, 256, "R6 curve");
    model(1, 9, 256);
    idle(BINS + 2);
    promote();
    send(0, 30, 128, "R10 accepted");
    chk(!overrun_o, "R10 no overrun", overrun_o, 0);
    model(0, 30, 128);
    // BINS+1 idle cycles: overrun, old table kept, frame not counted
    idle(BINS + 1);
    send(3, 1, 64, "R8 old table kept");
    chk(overrun_o, "R8 overrun set", overrun_o, 1);
    idle(GAP);
    promote();
    send(2, 11, 256, "R8 deferred swap");
    model(2, 11, 256);
    idle(GAP);
    promote();
    send(1, 2, 100, "R3 fresh histogram");
    chk(overrun_o, "R8 overrun sticky", overrun_o, 1);
    idle(4);

    // R9 reset clears table and flag
    @(negedge clk);
    rst_ni = 1'b0;
    @(posedge clk);
    #1;
    chk(!valid_o && !overrun_o, "R9 reset clears", {valid_o, overrun_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(BINS + 4);
    exp_ok = 1'b0;
    send(4, 50, 256, "R9 R2 identity after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule